// File: doc/BRIEF.md
# Ratio-Selected Clock Divider Bank

This block turns one fast source clock into four families of divided clocks: a processor family, a memory family, a peripheral-bus family and a graphics-port family. A 4-bit joint ratio code sets the processor, memory and peripheral divisors together. A separate 3-bit code sets the graphics divisor. Both codes, together with per-output enable bits, arrive as static values from a register block elsewhere on the chip. Three active-low stop requests, which may arrive from any clock domain, halt the processor, memory and peripheral families. One processor output (the chipset copy) can be set to ignore the processor stop. A global float bit drops a shared output-enable that the pad ring uses to put every clock pin into high impedance.

Each family has one divider. The divider is a state machine with the states DIV_IDLE, DIV_HIGH and DIV_LOW. Reset puts it in DIV_IDLE. From DIV_IDLE it goes straight to DIV_HIGH and loads the requested divisor. DIV_HIGH moves to DIV_LOW once its high phase is complete. DIV_LOW goes back to DIV_HIGH at the end of the period, and the next divisor is loaded on that same transition. Each output has its own gate, a machine with the states GATE_OFF and GATE_ON. GATE_OFF moves to GATE_ON when the output is wanted and the divided clock is low. GATE_ON moves to GATE_OFF when the output is no longer wanted and the divided clock is low. The gate registers the final output pin.

Top module: `clkdiv_bank`

## Requirements
- R1: The ratio code sets the processor/memory/peripheral periods, counted in source cycles, as follows: 0000=2/2/10, 0001=2/3/10, 0010=3/2/10, 0011=3/3/10, 0100=3/3/12, 0101=3/3/16, 0110=3/4/12, 0111=3/4/16, 1000=4/3/10, 1001=4/3/12, 1010=4/3/16, 1011=4/4/12, 1100=4/6/12, 1101=6/3/12, 1110=6/4/12, 1111=6/6/12.
- R2: The graphics code sets the graphics period as follows: 000=3, 001=5, 010=6, 011=8, 100=4, 111=10. Reset selects 3.
- R3: The graphics codes 101 and 110 are undefined. While one of them is applied, the graphics period stays at the last defined selection.
- R4: For a divisor N, each output is high for (N+1)/2 source cycles (integer division) and low for the rest of the period. Divisor 3 therefore gives 2 high and 1 low, and divisor 5 gives 3 high and 2 low.
- R5: A divider loads a new divisor only at the end of its current period. When the code changes, the period already in progress completes at the old length, and the period after it has the new length.
- R6: An output whose enable bit is 0 stays low. Setting the bit back to 1 restarts the output at its selected period.
- R7: An enable or stop change never produces a shortened high pulse. Every high pulse on an output lasts exactly (N+1)/2 cycles.
- R8: While cpu_stop_n is low, the processor outputs stay low. The chipset output, which is the last processor index, also stops when cs_stop_follow is 1 and keeps running when cs_stop_follow is 0. The stop takes effect within 6 source cycles of the input change, after a two-flop synchronizer.
- R9: While pci_stop_n is low, only the peripheral outputs stop. While sdram_stop_n is low, only the memory outputs stop.
- R10: clk_oe is 0 within two cycles of float_all being set to 1, and returns to 1 within two cycles of float_all being cleared.
- R11: While rst_n is low, all clock outputs and clk_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock (synthesizer stand-in) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 4 | Joint processor/memory/peripheral ratio code |
| agp_code | input | 3 | Graphics ratio code |
| cpu_en | input | N_CPU | Per-output enable, processor family |
| sdram_en | input | N_SDRAM | Per-output enable, memory family |
| pci_en | input | N_PCI | Per-output enable, peripheral family |
| agp_en | input | N_AGP | Per-output enable, graphics family |
| cs_stop_follow | input | 1 | 1: chipset output obeys cpu_stop_n; 0: chipset output runs freely |
| cpu_stop_n | input | 1 | Asynchronous processor stop request, active low |
| sdram_stop_n | input | 1 | Asynchronous memory stop request, active low |
| pci_stop_n | input | 1 | Asynchronous peripheral stop request, active low |
| float_all | input | 1 | 1 floats all clock pads |
| cpu_clk | output | N_CPU | Processor clocks; the top index is the chipset copy |
| sdram_clk | output | N_SDRAM | Memory clocks |
| pci_clk | output | N_PCI | Peripheral clocks |
| agp_clk | output | N_AGP | Graphics clocks |
| clk_oe | output | 1 | Shared pad drive enable, 0 = high impedance |

## Verification
Two events can fall in the same source cycle: a divider wrapping to load a new divisor, and a gate deciding to open or close. Both act on the edge where the divided clock is low. The bench changes the ratio code just after an observed rising edge and expects one last period at the old length followed by periods at the new length. In a separate test it toggles an enable at eight different phases of a 16-cycle peripheral clock. During that test a monitor measures every high pulse and reports any pulse that differs from 8 cycles.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int DIV_W = 5;

    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_HIGH = 2'd1,
        DIV_LOW  = 2'd2
    } div_state_e;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] cpu;
        logic [DIV_W-1:0] sdram;
        logic [DIV_W-1:0] pci;
    } ratio_set_t;

    function automatic ratio_set_t decode_ratio(input logic [3:0] code);
        ratio_set_t r;
        unique case (code)
            4'h0: r = '{cpu: 5'd2, sdram: 5'd2, pci: 5'd10};
            4'h1: r = '{cpu: 5'd2, sdram: 5'd3, pci: 5'd10};
            4'h2: r = '{cpu: 5'd3, sdram: 5'd2, pci: 5'd10};
            4'h3: r = '{cpu: 5'd3, sdram: 5'd3, pci: 5'd10};
            4'h4: r = '{cpu: 5'd3, sdram: 5'd3, pci: 5'd12};
            4'h5: r = '{cpu: 5'd3, sdram: 5'd3, pci: 5'd16};
            4'h6: r = '{cpu: 5'd3, sdram: 5'd4, pci: 5'd12};
            4'h7: r = '{cpu: 5'd3, sdram: 5'd4, pci: 5'd16};
            4'h8: r = '{cpu: 5'd4, sdram: 5'd3, pci: 5'd10};
            4'h9: r = '{cpu: 5'd4, sdram: 5'd3, pci: 5'd12};
            4'hA: r = '{cpu: 5'd4, sdram: 5'd3, pci: 5'd16};
            4'hB: r = '{cpu: 5'd4, sdram: 5'd4, pci: 5'd12};
            4'hC: r = '{cpu: 5'd4, sdram: 5'd6, pci: 5'd12};
            4'hD: r = '{cpu: 5'd6, sdram: 5'd3, pci: 5'd12};
            4'hE: r = '{cpu: 5'd6, sdram: 5'd4, pci: 5'd12};
            default: r = '{cpu: 5'd6, sdram: 5'd6, pci: 5'd12};
        endcase
        return r;
    endfunction

    // Returns 0 for the two undefined codes; caller treats 0 as "keep".
    function automatic logic [DIV_W-1:0] decode_agp(input logic [2:0] code);
        logic [DIV_W-1:0] d;
        unique case (code)
            3'b000:  d = 5'd3;
            3'b001:  d = 5'd5;
            3'b010:  d = 5'd6;
            3'b011:  d = 5'd8;
            3'b100:  d = 5'd4;
            3'b111:  d = 5'd10;
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_req_i,
    output logic             div_o
);

    div_state_e       state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] div_cur_q, div_cur_d;
    logic [DIV_W-1:0] hi_last;
    logic [DIV_W-1:0] per_last;

    always_comb begin
        hi_last  = DIV_W'((div_cur_q + DIV_W'(1)) >> 1) - DIV_W'(1);
        per_last = div_cur_q - DIV_W'(1);
    end

    // next-state process
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        div_cur_d = div_cur_q;
        unique case (state_q)
            DIV_IDLE: begin
                state_d   = DIV_HIGH;
                cnt_d     = '0;
                div_cur_d = div_req_i;
            end
            DIV_HIGH: begin
                cnt_d = cnt_q + DIV_W'(1);
                if (cnt_q == hi_last) state_d = DIV_LOW;
            end
            DIV_LOW: begin
                if (cnt_q == per_last) begin
                    state_d   = DIV_HIGH;
                    cnt_d     = '0;
                    div_cur_d = div_req_i;
                end else begin
                    cnt_d = cnt_q + DIV_W'(1);
                end
            end
            default: state_d = DIV_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= DIV_IDLE;
            cnt_q     <= '0;
            div_cur_q <= DIV_W'(2);
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            div_cur_q <= div_cur_d;
        end
    end

    // output process
    always_comb begin
        div_o = (state_q == DIV_HIGH);
    end

    // R1
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != DIV_IDLE) |-> (cnt_q < div_cur_q));

    // R5
    div_hold_midcycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_HIGH || (state_q == DIV_LOW && cnt_q != per_last))
        |=> $stable(div_cur_q));

endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic div_i,
    input  logic want_i,
    output logic clk_o
);

    gate_state_e gate_q, gate_d;
    logic        out_q;

    always_comb begin
        gate_d = gate_q;
        unique case (gate_q)
            GATE_OFF: if (!div_i && want_i)  gate_d = GATE_ON;
            GATE_ON:  if (!div_i && !want_i) gate_d = GATE_OFF;
            default:  gate_d = GATE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= GATE_OFF;
        else        gate_q <= gate_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= div_i && (gate_q == GATE_ON);
    end

    assign clk_o = out_q;

    // R7
    gate_only_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_i |=> $stable(gate_q));

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int N_CPU   = 3,
    parameter int N_SDRAM = 13,
    parameter int N_PCI   = 6,
    parameter int N_AGP   = 2
) (
    input  logic               clk_src,
    input  logic               rst_n,
    input  logic [3:0]         ratio_code,
    input  logic [2:0]         agp_code,
    input  logic [N_CPU-1:0]   cpu_en,
    input  logic [N_SDRAM-1:0] sdram_en,
    input  logic [N_PCI-1:0]   pci_en,
    input  logic [N_AGP-1:0]   agp_en,
    input  logic               cs_stop_follow,
    input  logic               cpu_stop_n,
    input  logic               sdram_stop_n,
    input  logic               pci_stop_n,
    input  logic               float_all,
    output logic [N_CPU-1:0]   cpu_clk,
    output logic [N_SDRAM-1:0] sdram_clk,
    output logic [N_PCI-1:0]   pci_clk,
    output logic [N_AGP-1:0]   agp_clk,
    output logic               clk_oe
);

    localparam int CS_IDX = N_CPU - 1;
    localparam logic [DIV_W-1:0] AGP_RST_DIV = DIV_W'(3);

    ratio_set_t       ratio;
    logic [DIV_W-1:0] agp_dec;
    logic             agp_legal;
    logic [DIV_W-1:0] agp_div_q;
    logic [2:0]       stop_s;
    logic             cpu_run, sdram_run, pci_run;
    logic             div_cpu, div_sdram, div_pci, div_agp;
    logic             oe_q;

    always_comb begin
        ratio     = decode_ratio(ratio_code);
        agp_dec   = decode_agp(agp_code);
        agp_legal = (agp_dec != '0);
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n)         agp_div_q <= AGP_RST_DIV;
        else if (agp_legal) agp_div_q <= agp_dec;
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= !float_all;
    end
    assign clk_oe = oe_q;

    clkdiv_sync #(.W(3), .RST_VAL(3'b111)) u_stop_sync (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .async_i ({cpu_stop_n, sdram_stop_n, pci_stop_n}),
        .sync_o  (stop_s)
    );
    assign cpu_run   = stop_s[2];
    assign sdram_run = stop_s[1];
    assign pci_run   = stop_s[0];

    clkdiv_counter u_div_cpu   (.clk(clk_src), .rst_n(rst_n), .div_req_i(ratio.cpu),   .div_o(div_cpu));
    clkdiv_counter u_div_sdram (.clk(clk_src), .rst_n(rst_n), .div_req_i(ratio.sdram), .div_o(div_sdram));
    clkdiv_counter u_div_pci   (.clk(clk_src), .rst_n(rst_n), .div_req_i(ratio.pci),   .div_o(div_pci));
    clkdiv_counter u_div_agp   (.clk(clk_src), .rst_n(rst_n), .div_req_i(agp_div_q),   .div_o(div_agp));

    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        logic want;
        if (i == CS_IDX) begin : g_cs
            assign want = cpu_en[i] && (cpu_run || !cs_stop_follow);
        end else begin : g_plain
            assign want = cpu_en[i] && cpu_run;
        end
        clkdiv_gate u_gate (.clk(clk_src), .rst_n(rst_n), .div_i(div_cpu),
                            .want_i(want), .clk_o(cpu_clk[i]));
    end

    for (genvar i = 0; i < N_SDRAM; i++) begin : g_sdram
        clkdiv_gate u_gate (.clk(clk_src), .rst_n(rst_n), .div_i(div_sdram),
                            .want_i(sdram_en[i] && sdram_run), .clk_o(sdram_clk[i]));
    end

    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
        clkdiv_gate u_gate (.clk(clk_src), .rst_n(rst_n), .div_i(div_pci),
                            .want_i(pci_en[i] && pci_run), .clk_o(pci_clk[i]));
    end

    for (genvar i = 0; i < N_AGP; i++) begin : g_agp
        clkdiv_gate u_gate (.clk(clk_src), .rst_n(rst_n), .div_i(div_agp),
                            .want_i(agp_en[i]), .clk_o(agp_clk[i]));
    end

    // R3
    agp_undefined_hold_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        !agp_legal |=> $stable(agp_div_q));

    // R2
    agp_div_legal_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (agp_div_q == 5'd3 || agp_div_q == 5'd4 || agp_div_q == 5'd5 ||
         agp_div_q == 5'd6 || agp_div_q == 5'd8 || agp_div_q == 5'd10));

endmodule

// File: tb/clkdiv_bank_bench.sv
module clkdiv_bank_bench;

    localparam int N_CPU = 3, N_SDRAM = 13, N_PCI = 6, N_AGP = 2;
    localparam int CS = N_CPU - 1;

    logic clk_src = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] ratio_code = 4'h0;
    logic [2:0] agp_code = 3'b000;
    logic [N_CPU-1:0]   cpu_en = '1;
    logic [N_SDRAM-1:0] sdram_en = '1;
    logic [N_PCI-1:0]   pci_en = '1;
    logic [N_AGP-1:0]   agp_en = '1;
    logic cs_stop_follow = 1'b1;
    logic cpu_stop_n = 1'b1, sdram_stop_n = 1'b1, pci_stop_n = 1'b1;
    logic float_all = 1'b0;
    logic [N_CPU-1:0]   cpu_clk;
    logic [N_SDRAM-1:0] sdram_clk;
    logic [N_PCI-1:0]   pci_clk;
    logic [N_AGP-1:0]   agp_clk;
    logic clk_oe;

    int n_checks = 0, n_fails = 0;

    always #4 clk_src = ~clk_src;

    clkdiv_bank u_clkdiv_bank (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic clk_of(input int sel, input int idx);
        case (sel)
            0: return cpu_clk[idx];
            1: return sdram_clk[idx];
            2: return pci_clk[idx];
            default: return agp_clk[idx];
        endcase
    endfunction

    task automatic to_rise(input int sel, input int idx, output int n);
        logic prev, cur;
        n = 0;
        cur = clk_of(sel, idx);
        do begin
            prev = cur;
            @(negedge clk_src);
            n++;
            cur = clk_of(sel, idx);
        end while (!(prev == 1'b0 && cur == 1'b1) && n < 200);
    endtask

    task automatic measure(input int sel, input int idx, output int per, output int hi);
        int dummy;
        logic prev, cur;
        to_rise(sel, idx, dummy);
        per = 0; hi = 0;
        cur = 1'b1;
        do begin
            if (cur) hi++;
            prev = cur;
            @(negedge clk_src);
            per++;
            cur = clk_of(sel, idx);
        end while (!(prev == 1'b0 && cur == 1'b1) && per < 200);
    endtask

    task automatic rises(input int sel, input int idx, input int win, output int n);
        logic prev, cur;
        n = 0;
        cur = clk_of(sel, idx);
        repeat (win) begin
            prev = cur;
            @(negedge clk_src);
            cur = clk_of(sel, idx);
            if (!prev && cur) n++;
        end
    endtask

    // pulse-width monitor for the runt test
    bit mon_on = 0;
    int mon_len = 0, mon_bad = 0, mon_seen = 0, mon_exp = 8;
    always @(negedge clk_src) begin
        if (mon_on) begin
            if (pci_clk[0]) mon_len++;
            else if (mon_len != 0) begin
                mon_seen++;
                if (mon_len != mon_exp) mon_bad++;
                mon_len = 0;
            end
        end else mon_len = 0;
    end

    task automatic t_reset;
        repeat (3) @(negedge clk_src);
        check(cpu_clk == '0 && sdram_clk == '0 && pci_clk == '0 && agp_clk == '0,
              "R11 clocks low in reset", int'(|{cpu_clk, sdram_clk, pci_clk, agp_clk}), 0);
        check(clk_oe == 1'b0, "R11 oe low in reset", clk_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_src);
        check(clk_oe == 1'b1, "R10 oe high after reset", clk_oe, 1);
    endtask

    task automatic t_ratio;
        logic [3:0] codes[4] = '{4'h0, 4'h5, 4'hC, 4'hF};
        int ec[4] = '{2, 3, 4, 6};
        int es[4] = '{2, 3, 6, 6};
        int ep[4] = '{10, 16, 12, 12};
        int p, h;
        for (int k = 0; k < 4; k++) begin
            ratio_code = codes[k];
            repeat (40) @(negedge clk_src);
            measure(0, 0, p, h);  check(p == ec[k], "R1 cpu period", p, ec[k]);
            measure(1, 5, p, h);  check(p == es[k], "R1 sdram period", p, es[k]);
            measure(2, 3, p, h);  check(p == ep[k], "R1 pci period", p, ep[k]);
            check(h == ep[k] / 2, "R4 pci high width", h, ep[k] / 2);
        end
    endtask

    task automatic t_agp;
        logic [2:0] codes[5] = '{3'b000, 3'b001, 3'b011, 3'b100, 3'b111};
        int ed[5] = '{3, 5, 8, 4, 10};
        int p, h;
        for (int k = 0; k < 5; k++) begin
            agp_code = codes[k];
            repeat (40) @(negedge clk_src);
            measure(3, 1, p, h);
            check(p == ed[k], "R2 agp period", p, ed[k]);
            check(h == (ed[k] + 1) / 2, "R4 agp high width", h, (ed[k] + 1) / 2);
        end
    endtask

    task automatic t_agp_undef;
        int p, h;
        agp_code = 3'b011;
        repeat (40) @(negedge clk_src);
        agp_code = 3'b101;
        repeat (40) @(negedge clk_src);
        measure(3, 0, p, h);
        check(p == 8, "R3 code 101 keeps period", p, 8);
        agp_code = 3'b110;
        repeat (40) @(negedge clk_src);
        measure(3, 0, p, h);
        check(p == 8, "R3 code 110 keeps period", p, 8);
    endtask

    task automatic t_switch;
        int n;
        ratio_code = 4'h0;
        repeat (30) @(negedge clk_src);
        to_rise(0, 0, n);
        ratio_code = 4'hD;
        to_rise(0, 0, n);
        check(n == 2, "R5 period in progress keeps old length", n, 2);
        to_rise(0, 0, n);
        check(n == 6, "R5 next period uses new length", n, 6);
    endtask

    task automatic t_enable;
        int n, p, h;
        ratio_code = 4'h5;
        repeat (40) @(negedge clk_src);
        pci_en[2] = 1'b0;
        repeat (20) @(negedge clk_src);
        rises(2, 2, 60, n);
        check(n == 0, "R6 disabled output stays low", n, 0);
        rises(2, 1, 60, n);
        check(n > 0, "R6 neighbour keeps running", n, 1);
        pci_en[2] = 1'b1;
        repeat (20) @(negedge clk_src);
        measure(2, 2, p, h);
        check(p == 16, "R6 re-enabled period", p, 16);
        mon_on = 1;
        for (int k = 0; k < 8; k++) begin
            repeat (k + 3) @(negedge clk_src);
            pci_en[0] = 1'b0;
            repeat (5 + 2 * k) @(negedge clk_src);
            pci_en[0] = 1'b1;
        end
        repeat (40) @(negedge clk_src);
        mon_on = 0;
        check(mon_bad == 0, "R7 no shortened pulse on enable toggling", mon_bad, 0);
        check(mon_seen > 0, "R7 pulses observed", mon_seen, 1);
    endtask

    task automatic t_cpu_stop;
        int n;
        ratio_code = 4'h0;
        cs_stop_follow = 1'b1;
        repeat (20) @(negedge clk_src);
        cpu_stop_n = 1'b0;
        repeat (6) @(negedge clk_src);
        rises(0, 0, 40, n); check(n == 0, "R8 cpu0 stopped", n, 0);
        rises(0, CS, 40, n); check(n == 0, "R8 chipset stops when following", n, 0);
        rises(1, 0, 40, n); check(n > 0, "R8 sdram unaffected", n, 1);
        cs_stop_follow = 1'b0;
        repeat (10) @(negedge clk_src);
        rises(0, CS, 40, n); check(n > 0, "R8 chipset free running", n, 1);
        rises(0, 1, 40, n); check(n == 0, "R8 cpu1 still stopped", n, 0);
        cpu_stop_n = 1'b1;
        repeat (10) @(negedge clk_src);
        rises(0, 0, 40, n); check(n > 0, "R8 cpu0 resumes", n, 1);
    endtask

    task automatic t_other_stop;
        int n;
        pci_stop_n = 1'b0;
        repeat (20) @(negedge clk_src);
        rises(2, 0, 60, n); check(n == 0, "R9 pci stopped", n, 0);
        rises(1, 0, 40, n); check(n > 0, "R9 sdram runs during pci stop", n, 1);
        pci_stop_n = 1'b1;
        sdram_stop_n = 1'b0;
        repeat (20) @(negedge clk_src);
        rises(1, 12, 40, n); check(n == 0, "R9 sdram stopped", n, 0);
        rises(2, 0, 60, n); check(n > 0, "R9 pci runs during sdram stop", n, 1);
        sdram_stop_n = 1'b1;
    endtask

    task automatic t_float;
        float_all = 1'b1;
        repeat (2) @(negedge clk_src);
        check(clk_oe == 1'b0, "R10 oe drops when floating", clk_oe, 0);
        float_all = 1'b0;
        repeat (2) @(negedge clk_src);
        check(clk_oe == 1'b1, "R10 oe returns", clk_oe, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_ratio();
                t_agp();
                t_agp_undef();
                t_switch();
                t_enable();
                t_cpu_stop();
                t_other_stop();
                t_float();
            end
            begin
                repeat (150000) @(posedge clk_src);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule